// File: doc/BRIEF.md
# Composite Sync Timing Extractor

This block takes a composite sync bit that has already been sliced from the analog video and sampled on the system clock, low during sync. From that bit it regenerates four active-low timing strobes: a registered copy of the composite sync, a horizontal sync of fixed width, a vertical sync, and a back-porch gate. All pulse widths are counted in system clock cycles and set by parameters. A two-bit mode input picks standard, enhanced or high-definition timing. In high-definition mode the input falling edge stands for the reference edge of a tri-level sync.

The block measures the line period between accepted reference edges. It uses that period to reject edges that arrive at half-line points, such as equalising and serration pulses. It also uses it to recognise the broad pulses that mark the vertical interval. A lock flag rises once enough vertical intervals have been seen. A user should take the outputs as valid only while that flag is high.

Top module: `sync_timing_extractor`

## Requirements
- R1: While reset is low and right after it, hsync_n, vsync_n and bporch_n are high (idle) and locked is low.
- R2: csync_n_out equals csync_n_in as sampled at the previous clock edge.
- R3: An accepted input falling edge makes hsync_n fall two clocks after the input first reads low. hsync_n stays low for exactly HS_SD, HS_ED or HS_HD clocks, chosen by mode (0 = standard, 1 = enhanced, 2 or 3 = high definition).
- R4: A falling edge is accepted only when no period is known yet, or when at least three quarters of the measured line period have passed since the previous accepted edge. Other falling edges produce no hsync_n pulse.
- R5: The hsync_n width stays at the mode width while the input is held low by broad vertical pulses.
- R6: vsync_n falls two clocks after an input low has lasted one quarter of the measured period. This applies to the first such pulse of a vertical interval. vsync_n rises together with the hsync_n fall of the third accepted edge after that.
- R7: In modes 0 and 1, bporch_n falls two clocks after an input rising edge. Its width is BP_SD in mode 0 outside the vertical sync, BP_SD_VERT in mode 0 while vsync_n is low, and BP_ED on every pulse in mode 1.
- R8: In modes 2 and 3, bporch_n falls HD_TIP clocks after hsync_n falls and stays low for BP_HD clocks. Input rising edges start no back-porch pulse.
- R9: locked rises in the same cycle as the vsync_n fall of the LOCK_FIELDS-th vertical interval. A change of mode clears it.
- R10: If no input falling edge arrives for LOSS_CYC clocks, locked is cleared, vsync is released and the measured period is forgotten, so the next two edges are both accepted whatever their spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Timing family: 0 standard, 1 enhanced, 2/3 high definition |
| csync_n_in | input | 1 | Sliced composite sync, low during sync |
| csync_n_out | output | 1 | Registered copy of the composite sync |
| hsync_n | output | 1 | Regenerated horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| bporch_n | output | 1 | Back-porch gate, active low |
| locked | output | 1 | Outputs valid |

## Verification
The hardest state to reach is the vertical interval. There, half-line equalising pulses, broad pulses with short serrations, and the end of vertical sync all have to meet a line period the block has already learned. The bench first sends several normal lines so the period settles. It then plays a full interval made of six equalising half-lines, six broad half-lines and six equalising half-lines. Against the stamped input edges it checks the count of suppressed edges, the vsync delay and width, the fixed hsync width and the shortened porch gate. Two such intervals in a row are needed to bring the lock flag up.

// File: rtl/sx_pkg.sv
// Shared types for the composite sync timing extractor.
package sx_pkg;
    // Timing family selected by the mode input; both upper codes mean high definition.
    typedef enum logic [1:0] {
        FMT_SD     = 2'd0,
        FMT_ED     = 2'd1,
        FMT_HD     = 2'd2,
        FMT_HD_ALT = 2'd3
    } fmt_e;
endpackage

// File: rtl/sx_edge_classifier.sv
// Registers the sliced sync, finds its edges and measures each low pulse.
// Assumes the input is already synchronous to clk.
// A low that reaches the threshold is reported once as a broad pulse.
module sx_edge_classifier #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n_in,
    input  logic [CNT_W-1:0] thr,
    output logic             sync_q,
    output logic             fall,
    output logic             rise,
    output logic             broad_hit,
    output logic             short_end
);
    logic             sync_d;
    logic [CNT_W-1:0] lo_cnt;

    // Two-stage sample of the input; both idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b1;
            sync_d <= 1'b1;
        end else begin
            sync_q <= sync_n_in;
            sync_d <= sync_q;
        end
    end

    // Length of the current low pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_cnt <= '0;
        else if (!sync_q) begin
            if (lo_cnt != {CNT_W{1'b1}})
                lo_cnt <= lo_cnt + 1'b1;
        end else
            lo_cnt <= '0;
    end

    // Edge and pulse-class decode.
    always_comb begin
        fall      = sync_d & ~sync_q;
        rise      = ~sync_d & sync_q;
        broad_hit = ~sync_q && (thr != '0) && (lo_cnt == thr);
        short_end = rise && ((thr == '0) || (lo_cnt < thr));
    end
endmodule

// File: rtl/sx_line_tracker.sv
// Measures the line period and accepts only edges near the predicted line start.
// Regenerates a fixed-width horizontal sync and flags signal loss.
// Assumes flush arrives from the top as a one-cycle clear.
module sx_line_tracker #(
    parameter int CNT_W    = 16,
    parameter int HS_SD    = 250,
    parameter int HS_ED    = 230,
    parameter int HS_HD    = 40,
    parameter int LOSS_CYC = 32000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             fall,
    input  logic             flush,
    output logic             accept,
    output logic [CNT_W-1:0] period,
    output logic             hsync_n,
    output logic             lost
);
    import sx_pkg::*;

    logic [CNT_W-1:0] since_acc;
    logic [CNT_W-1:0] idle;
    logic [CNT_W-1:0] hs_cnt;
    logic             seen;
    logic [CNT_W:0]   elapsed;
    logic [CNT_W:0]   min_gap;
    logic [CNT_W-1:0] hs_width;

    // Acceptance window and width for the current mode.
    always_comb begin
        elapsed = {1'b0, since_acc} + {{CNT_W{1'b0}}, 1'b1};
        min_gap = {1'b0, period - (period >> 2)};
        accept  = fall && ((period == '0) || (elapsed >= min_gap));
        lost    = (idle == CNT_W'(LOSS_CYC - 1)) && !fall;
        case (fmt_e'(mode))
            FMT_SD:  hs_width = CNT_W'(HS_SD);
            FMT_ED:  hs_width = CNT_W'(HS_ED);
            default: hs_width = CNT_W'(HS_HD);
        endcase
    end

    // Cycles since the last accepted edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_acc <= '0;
        else if (accept)
            since_acc <= '0;
        else if (since_acc != {CNT_W{1'b1}})
            since_acc <= since_acc + 1'b1;
    end

    // Period learning: the first accepted edge only marks a start.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            period <= '0;
            seen   <= 1'b0;
        end else if (accept) begin
            seen <= 1'b1;
            if (seen)
                period <= elapsed[CNT_W-1:0];
        end
    end

    // Cycles since any falling edge, for loss detection.
    always_ff @(posedge clk) begin
        if (!rst_n || fall)
            idle <= '0;
        else if (idle < CNT_W'(LOSS_CYC))
            idle <= idle + 1'b1;
    end

    // Fixed-width horizontal sync, restarted by each accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hs_cnt <= '0;
        else if (accept)
            hs_cnt <= hs_width;
        else if (hs_cnt != '0)
            hs_cnt <= hs_cnt - 1'b1;
    end

    assign hsync_n = (hs_cnt == '0);
endmodule

// File: rtl/sx_vert_detect.sv
// Starts vertical sync on the first broad pulse of an interval and holds it
// for a fixed number of accepted lines. Counts intervals to raise lock.
// Re-arms only after a short sync pulse ends outside vertical sync.
module sx_vert_detect #(
    parameter int VS_LINES    = 3,
    parameter int LOCK_FIELDS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic broad_hit,
    input  logic short_end,
    input  logic accept,
    output logic vs_active,
    output logic locked
);
    localparam int VL_W = $clog2(VS_LINES + 1);
    localparam int FL_W = $clog2(LOCK_FIELDS + 1);

    logic            armed;
    logic [VL_W-1:0] vs_lines;
    logic [FL_W-1:0] fields;

    // Vertical sync sequencing and lock counting.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vs_active <= 1'b0;
            armed     <= 1'b1;
            vs_lines  <= '0;
            fields    <= '0;
            locked    <= 1'b0;
        end else if (armed && broad_hit) begin
            vs_active <= 1'b1;
            armed     <= 1'b0;
            vs_lines  <= '0;
            if (fields < FL_W'(LOCK_FIELDS))
                fields <= fields + 1'b1;
            if (fields == FL_W'(LOCK_FIELDS - 1))
                locked <= 1'b1;
        end else if (vs_active && accept) begin
            if (vs_lines == VL_W'(VS_LINES - 1))
                vs_active <= 1'b0;
            vs_lines <= vs_lines + 1'b1;
        end else if (!vs_active && !armed && short_end) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/sx_porch_gen.sv
// Back-porch gate generator. In standard and enhanced modes it fires on the
// input rising edge; in high-definition mode a fixed delay after the accepted
// reference edge stands for the tri-level trailing edge.
module sx_porch_gen #(
    parameter int CNT_W      = 16,
    parameter int BP_SD      = 320,
    parameter int BP_SD_VERT = 120,
    parameter int BP_ED      = 35,
    parameter int BP_HD      = 30,
    parameter int HD_TIP     = 59
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       rise,
    input  logic       accept,
    input  logic       vert,
    output logic       bporch_n
);
    import sx_pkg::*;

    logic [CNT_W-1:0] tip_cnt;
    logic [CNT_W-1:0] bp_cnt;
    logic [CNT_W-1:0] bp_width;
    logic             trig;

    // Trigger source and gate width per mode.
    always_comb begin
        case (fmt_e'(mode))
            FMT_SD: begin
                trig     = rise;
                bp_width = vert ? CNT_W'(BP_SD_VERT) : CNT_W'(BP_SD);
            end
            FMT_ED: begin
                trig     = rise;
                bp_width = CNT_W'(BP_ED);
            end
            default: begin
                trig     = (tip_cnt == {{(CNT_W-1){1'b0}}, 1'b1});
                bp_width = CNT_W'(BP_HD);
            end
        endcase
    end

    // Delay from reference edge to trailing edge in high-definition mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tip_cnt <= '0;
        else if (mode[1] && accept)
            tip_cnt <= CNT_W'(HD_TIP);
        else if (tip_cnt != '0)
            tip_cnt <= tip_cnt - 1'b1;
    end

    // Gate width countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bp_cnt <= '0;
        else if (trig)
            bp_cnt <= bp_width;
        else if (bp_cnt != '0)
            bp_cnt <= bp_cnt - 1'b1;
    end

    assign bporch_n = (bp_cnt == '0);
endmodule

// File: rtl/sync_timing_extractor.sv
// Top level: ties edge classification, line tracking, vertical detection and
// porch gating together. Assumes csync_n_in is synchronous to clk.
// A mode change or signal loss flushes the learned state.
module sync_timing_extractor #(
    parameter int CNT_W       = 16,
    parameter int HS_SD       = 250,
    parameter int HS_ED       = 230,
    parameter int HS_HD       = 40,
    parameter int BP_SD       = 320,
    parameter int BP_SD_VERT  = 120,
    parameter int BP_ED       = 35,
    parameter int BP_HD       = 30,
    parameter int HD_TIP      = 59,
    parameter int VS_LINES    = 3,
    parameter int LOCK_FIELDS = 2,
    parameter int LOSS_CYC    = 32000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       csync_n_in,
    output logic       csync_n_out,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic       bporch_n,
    output logic       locked
);
    localparam int HS_MAX = (HS_SD > HS_ED) ? ((HS_SD > HS_HD) ? HS_SD : HS_HD)
                                            : ((HS_ED > HS_HD) ? HS_ED : HS_HD);

    logic [1:0]       mode_q;
    logic             flush;
    logic             fall, rise, broad_hit, short_end;
    logic             accept, lost, vs_active;
    logic [CNT_W-1:0] period;

    // Remember the mode to spot a change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 2'd0;
        else
            mode_q <= mode;
    end

    assign flush = lost || (mode != mode_q);

    sx_edge_classifier #(.CNT_W(CNT_W)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_n_in (csync_n_in),
        .thr       (period >> 2),
        .sync_q    (csync_n_out),
        .fall      (fall),
        .rise      (rise),
        .broad_hit (broad_hit),
        .short_end (short_end)
    );

    sx_line_tracker #(
        .CNT_W(CNT_W), .HS_SD(HS_SD), .HS_ED(HS_ED), .HS_HD(HS_HD), .LOSS_CYC(LOSS_CYC)
    ) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .fall    (fall),
        .flush   (flush),
        .accept  (accept),
        .period  (period),
        .hsync_n (hsync_n),
        .lost    (lost)
    );

    sx_vert_detect #(.VS_LINES(VS_LINES), .LOCK_FIELDS(LOCK_FIELDS)) u_vert (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .broad_hit (broad_hit),
        .short_end (short_end),
        .accept    (accept),
        .vs_active (vs_active),
        .locked    (locked)
    );

    sx_porch_gen #(
        .CNT_W(CNT_W), .BP_SD(BP_SD), .BP_SD_VERT(BP_SD_VERT), .BP_ED(BP_ED),
        .BP_HD(BP_HD), .HD_TIP(HD_TIP)
    ) u_porch (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .rise     (rise),
        .accept   (accept),
        .vert     (vs_active),
        .bporch_n (bporch_n)
    );

    assign vsync_n = ~vs_active;
endmodule

// File: rtl/sx_checker.sv
// Property checker for the extractor, attached by bind.
module sx_checker #(
    parameter int HS_MAX = 250
) (
    input logic clk,
    input logic rst_n,
    input logic csync_n_in,
    input logic hsync_n,
    input logic vsync_n,
    input logic bporch_n,
    input logic locked
);
    int hs_low;

    // Length of the current hsync low, observed from the port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hs_low <= 0;
        else if (!hsync_n)
            hs_low <= hs_low + 1;
        else
            hs_low <= 0;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hsync_n && vsync_n && bporch_n && !locked));

    a_r3_hs_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
        hs_low <= HS_MAX);

    a_r6_vs_during_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> !$past(csync_n_in, 2));

    a_r9_lock_with_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $fell(vsync_n));
endmodule

bind sync_timing_extractor sx_checker #(.HS_MAX(HS_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csync_n_in (csync_n_in),
    .hsync_n    (hsync_n),
    .vsync_n    (vsync_n),
    .bporch_n   (bporch_n),
    .locked     (locked)
);

// File: tb/sync_timing_extractor_bench.sv
module sync_timing_extractor_bench;
    localparam int LINE   = 200;
    localparam int HALF   = 100;
    localparam int SYNC_W = 16;
    localparam int EQ_W   = 8;
    localparam int BRD_W  = 80;
    localparam int HS_SD = 20, HS_ED = 18, HS_HD = 5;
    localparam int BP_SD = 30, BP_SDV = 12, BP_ED = 8, BP_HD = 4, HD_TIP = 6;
    localparam int LOSS = 1000;

    logic clk = 0, rst_n = 0, csync_n_in = 1;
    logic [1:0] mode = 2'd0;
    logic csync_n_out, hsync_n, vsync_n, bporch_n, locked;

    int checks = 0, errors = 0;
    bit done = 0;
    int cyc = 0;
    int in_fall_at, in_rise_at;
    int hs_fall_at, hs_w, hs_w_max, hs_falls;
    int bp_fall_at, bp_w, bp_falls;
    int vs_fall_at, vs_w, vs_falls;
    logic p_hs = 1, p_bp = 1, p_vs = 1;

    always #5 clk = ~clk;

    sync_timing_extractor #(
        .CNT_W(16), .HS_SD(HS_SD), .HS_ED(HS_ED), .HS_HD(HS_HD),
        .BP_SD(BP_SD), .BP_SD_VERT(BP_SDV), .BP_ED(BP_ED), .BP_HD(BP_HD),
        .HD_TIP(HD_TIP), .VS_LINES(3), .LOCK_FIELDS(2), .LOSS_CYC(LOSS)
    ) u_sync_timing_extractor (
        .clk(clk), .rst_n(rst_n), .mode(mode), .csync_n_in(csync_n_in),
        .csync_n_out(csync_n_out), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .bporch_n(bporch_n), .locked(locked)
    );

    // Output monitor: stamps every edge shortly after each rising clock edge.
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        if (p_hs && !hsync_n) begin hs_fall_at = cyc; hs_falls++; end
        if (!p_hs && hsync_n) begin
            hs_w = cyc - hs_fall_at;
            if (hs_w > hs_w_max) hs_w_max = hs_w;
        end
        if (p_bp && !bporch_n) begin bp_fall_at = cyc; bp_falls++; end
        if (!p_bp && bporch_n) bp_w = cyc - bp_fall_at;
        if (p_vs && !vsync_n) begin vs_fall_at = cyc; vs_falls++; end
        if (!p_vs && vsync_n) vs_w = cyc - vs_fall_at;
        p_hs = hsync_n; p_bp = bporch_n; p_vs = vsync_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One sync pulse: low for 'low' cycles within 'total'; starts and ends at a falling clock edge.
    task automatic pulse(input int low, input int total);
        csync_n_in = 0; in_fall_at = cyc;
        repeat (low) @(negedge clk);
        csync_n_in = 1; in_rise_at = cyc;
        repeat (total - low) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk(hsync_n && vsync_n && bporch_n, "R1 idle outputs", {hsync_n, vsync_n, bporch_n}, 7);
        chk(!locked, "R1 lock low", locked, 0);
    endtask

    task automatic t_sd_lines();
        csync_n_in = 0;
        @(negedge clk);
        chk(csync_n_out == 0, "R2 copy low", csync_n_out, 0);
        repeat (SYNC_W - 1) @(negedge clk);
        csync_n_in = 1;
        @(negedge clk);
        chk(csync_n_out == 1, "R2 copy high", csync_n_out, 1);
        repeat (LINE - SYNC_W - 1) @(negedge clk);
        repeat (3) pulse(SYNC_W, LINE);
        chk(hs_fall_at - in_fall_at == 2, "R3 hsync delay", hs_fall_at - in_fall_at, 2);
        chk(hs_w == HS_SD, "R3 hsync width SD", hs_w, HS_SD);
        chk(bp_fall_at - in_rise_at == 2, "R7 porch delay SD", bp_fall_at - in_rise_at, 2);
        chk(bp_w == BP_SD, "R7 porch width SD", bp_w, BP_SD);
    endtask

    task automatic t_field(input int idx);
        int h0, v0;
        repeat (3) pulse(SYNC_W, LINE);
        h0 = hs_falls;
        repeat (6) pulse(EQ_W, HALF);
        chk(hs_falls - h0 == 3, "R4 half-line edges suppressed", hs_falls - h0, 3);
        v0 = vs_falls; hs_w_max = 0;
        pulse(BRD_W, HALF);
        chk(vs_falls - v0 == 1, "R6 vsync started", vs_falls - v0, 1);
        chk(vs_fall_at - in_fall_at == LINE / 4 + 2, "R6 vsync delay", vs_fall_at - in_fall_at, LINE / 4 + 2);
        chk(bp_w == BP_SDV, "R7 porch short in vsync", bp_w, BP_SDV);
        repeat (5) pulse(BRD_W, HALF);
        chk(hs_w_max == HS_SD, "R5 hsync width over broad pulses", hs_w_max, HS_SD);
        chk(vs_falls - v0 == 1, "R6 single vsync per interval", vs_falls - v0, 1);
        repeat (6) pulse(EQ_W, HALF);
        chk(vs_w == 3 * LINE - LINE / 4, "R6 vsync width", vs_w, 3 * LINE - LINE / 4);
        chk(locked == (idx >= 2), "R9 lock after fields", locked, (idx >= 2));
        repeat (3) pulse(SYNC_W, LINE);
    endtask

    task automatic t_ed();
        mode = 2'd1;
        @(negedge clk);
        chk(!locked, "R9 mode change clears lock", locked, 0);
        repeat (4) pulse(SYNC_W, LINE);
        chk(hs_w == HS_ED, "R3 hsync width ED", hs_w, HS_ED);
        chk(bp_w == BP_ED, "R7 porch width ED", bp_w, BP_ED);
        chk(bp_fall_at - in_rise_at == 2, "R7 porch delay ED", bp_fall_at - in_rise_at, 2);
    endtask

    task automatic t_hd();
        int b0;
        mode = 2'd2;
        @(negedge clk);
        b0 = bp_falls;
        repeat (4) pulse(SYNC_W, LINE);
        chk(hs_w == HS_HD, "R3 hsync width HD", hs_w, HS_HD);
        chk(bp_fall_at - hs_fall_at == HD_TIP, "R8 porch offset HD", bp_fall_at - hs_fall_at, HD_TIP);
        chk(bp_w == BP_HD, "R8 porch width HD", bp_w, BP_HD);
        chk(bp_falls - b0 == 4, "R8 rises ignored HD", bp_falls - b0, 4);
    endtask

    task automatic t_loss();
        int h0;
        mode = 2'd0;
        @(negedge clk);
        repeat (4) pulse(SYNC_W, LINE);
        repeat (LOSS + 100) @(negedge clk);
        chk(!locked, "R10 lock cleared on loss", locked, 0);
        chk(hsync_n && vsync_n && bporch_n, "R10 outputs idle", {hsync_n, vsync_n, bporch_n}, 7);
        h0 = hs_falls;
        pulse(SYNC_W, HALF);
        pulse(SYNC_W, HALF);
        chk(hs_falls - h0 == 2, "R10 period forgotten", hs_falls - h0, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset_state();
        rst_n = 1;
        @(negedge clk);
        t_reset_state();
        t_sd_lines();
        t_field(1);
        t_field(2);
        t_ed();
        t_hd();
        t_loss();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule